// File: doc/BRIEF.md
# Serial Three-Wire Register Access Slave

This block is the slave end of a three-wire control link made of a mode line, a bus clock and one bidirectional data line (split here into an input, an output and an output-enable). A host microcontroller uses it to reach a bank of 16-bit registers. Each exchange opens with a header byte, sent while the mode line is low. The header carries a two-bit action code and a six-bit device address. Data bytes follow while the mode line is high.

Writing takes a header with the write action, a register-select byte and two data bytes. Reading is split into two exchanges. A write-action header with a register-select byte marked as a read stores a read pointer. A header with the fetch action then makes the slave drive three bytes back: a status byte that echoes the pointer with an existence flag, and the two data bytes.

All three bus lines are oversampled by the block's own system clock through synchronizers. The registers at addresses the valid map leaves out are not built at all.

Top module: `tw_reg_slave`

## Requirements
- R1: After reset every register reads zero, the read pointer is 0 and the data output-enable is low.
- R2: Bits are taken on rising bus-clock edges, MSB first. The header byte carries the action code in its first two bits (write = 01) and the device address in the next six, which must equal 011000. After a write header, a register byte whose first bit is 0 selects address A6..A0, and the next two bytes store D15..D0 into that register.
- R3: A register byte whose first bit is 1 stores A6..A0 as the read pointer. A later header with action 11 makes the slave return 24 bits. They are, in order: the flag (0 = register exists), the pointer A6..A0, then D15..D0.
- R4: With the default map (addresses 0 to 63 exist, 64 to 127 do not), a write to a missing address changes nothing. A fetch of it returns flag 1 and all-zero data.
- R5: A header whose device address is not 011000, or whose action is 00 or 10, makes the slave ignore every data byte until the next header, and it drives nothing.
- R6: A header allows one register operation only. Bytes after the fourth byte of a write, or after a read-request byte, have no effect.
- R7: The output-enable rises only in the data phase of a fetch. It stays high for exactly 24 bits and drops at the falling bus-clock edge that follows the 24th rising edge, or when the mode line falls.
- R8: A write does not change the stored read pointer.
- R9: The driven data bit changes only after a falling bus-clock edge and is held while the bus clock is high.
- R10: A header phase that does not contain exactly eight bits is treated like a non-matching header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | Low for the header phase, high for the data phase |
| bus_clk | input | 1 | Bus bit clock from the host |
| bus_din | input | 1 | Serial data from the host |
| bus_dout | output | 1 | Serial data driven back to the host |
| bus_doe | output | 1 | High while the slave owns the data line |

## Verification
Writes and fetches use data with the top bit set (8001, A5C3, FFFF) together with the lowest, highest and missing addresses. This exposes bit-order slips and lost flag bits. Headers are sent with a wrong device address, with the two unused action codes and with seven bits. In each case a fetch afterwards must show the old contents. Trailing bytes after a write and after a read request, and a write placed between prepare and fetch, separate one operation per header from a free-running decoder and show whether the pointer is kept. During every fetch the bench watches the output-enable edge and checks that each returned bit stays stable through the high half of the bus clock.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
// Shared types and codes for the three-wire register slave.
// Assumes MSB-first serial order on the bus.
package tw_pkg;

    // Decoder phase after a header has been judged
    typedef enum logic [2:0] {
        PH_IGNORE = 3'd0,
        PH_REGSEL = 3'd1,
        PH_DHI    = 3'd2,
        PH_DLO    = 3'd3,
        PH_FETCH  = 3'd4
    } phase_t;

    localparam logic [1:0] ACT_WRITE = 2'b01;
    localparam logic [1:0] ACT_FETCH = 2'b11;

endpackage

// File: rtl/tw_edge_sync.sv
`timescale 1ns/1ps
// Brings one asynchronous bus line into the clk domain and flags edges.
// Assumes the line holds each level for more than STAGES+1 clk cycles.
module tw_edge_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift chain and previous-level register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
            prev  <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;

endmodule

// File: rtl/tw_framer.sv
`timescale 1ns/1ps
// Collects serial bits into bytes on rising bus-clock edges.
// In the header phase it keeps a saturating bit count so that a header of
// the wrong length can be rejected. In the data phase it emits one strobe
// per completed byte. Any mode edge restarts the count.
module tw_framer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_lvl,
    input  logic              mode_rise,
    input  logic              mode_fall,
    input  logic              sclk_rise,
    input  logic              sdata,
    output logic [BYTE_W-1:0] hdr_byte,
    output logic              hdr_complete,
    output logic [BYTE_W-1:0] data_byte,
    output logic              data_strobe
);

    localparam int CW = $clog2(BYTE_W) + 2;

    logic [BYTE_W-1:0] shreg;
    logic [CW-1:0]     cnt;

    // Bit shifter, bit counter and byte strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            cnt         <= '0;
            data_byte   <= '0;
            data_strobe <= 1'b0;
        end else begin
            data_strobe <= 1'b0;
            if (mode_rise || mode_fall) begin
                cnt <= '0;
            end else if (sclk_rise) begin
                shreg <= {shreg[BYTE_W-2:0], sdata};
                if (mode_lvl) begin
                    if (cnt == CW'(BYTE_W - 1)) begin
                        cnt         <= '0;
                        data_strobe <= 1'b1;
                        data_byte   <= {shreg[BYTE_W-2:0], sdata};
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else if (cnt != '1) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign hdr_byte     = shreg;
    assign hdr_complete = (cnt == CW'(BYTE_W));

endmodule

// File: rtl/tw_ctrl.sv
`timescale 1ns/1ps
// Protocol decoder. It judges the header when the data phase opens, then
// walks register-select and data bytes. It emits a write pulse, keeps the
// read pointer and starts a fetch. Assumes DW is two bytes wide and that
// the register byte holds a read flag above an AW-bit address.
module tw_ctrl
    import tw_pkg::*;
#(
    parameter int          BYTE_W   = 8,
    parameter int          AW       = 7,
    parameter int          DW       = 16,
    parameter logic [5:0]  DEV_ADDR = 6'b011000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rise,
    input  logic              mode_fall,
    input  logic [BYTE_W-1:0] hdr_byte,
    input  logic              hdr_complete,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              data_strobe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [AW-1:0]     rd_ptr,
    output logic              fetch_start
);

    phase_t            phase;
    logic [BYTE_W-1:0] hi_byte;
    logic [1:0]        hdr_act;
    logic [5:0]        hdr_dev;
    logic              hdr_hit;

    // Split header into action and device fields
    always_comb begin
        hdr_act = hdr_byte[BYTE_W-1 -: 2];
        hdr_dev = hdr_byte[5:0];
        hdr_hit = hdr_complete && (hdr_dev == DEV_ADDR);
    end

    // Phase sequencing and register-operation capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IGNORE;
            hi_byte     <= '0;
            wr_en       <= 1'b0;
            wr_addr     <= '0;
            wr_data     <= '0;
            rd_ptr      <= '0;
            fetch_start <= 1'b0;
        end else begin
            wr_en       <= 1'b0;
            fetch_start <= 1'b0;
            if (mode_fall) begin
                phase <= PH_IGNORE;
            end else if (mode_rise) begin
                if (hdr_hit && hdr_act == ACT_WRITE) begin
                    phase <= PH_REGSEL;
                end else if (hdr_hit && hdr_act == ACT_FETCH) begin
                    phase       <= PH_FETCH;
                    fetch_start <= 1'b1;
                end else begin
                    phase <= PH_IGNORE;
                end
            end else if (data_strobe) begin
                case (phase)
                    PH_REGSEL: begin
                        if (data_byte[BYTE_W-1]) begin
                            rd_ptr <= data_byte[AW-1:0];
                            phase  <= PH_IGNORE;
                        end else begin
                            wr_addr <= data_byte[AW-1:0];
                            phase   <= PH_DHI;
                        end
                    end
                    PH_DHI: begin
                        hi_byte <= data_byte;
                        phase   <= PH_DLO;
                    end
                    PH_DLO: begin
                        wr_data <= {hi_byte, data_byte};
                        wr_en   <= 1'b1;
                        phase   <= PH_IGNORE;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_regbank.sv
`timescale 1ns/1ps
// Register bank with a compile-time existence map. Only the entries marked
// in VALID_MAP get storage; the others read as zero and drop writes.
// Assumes a single write port and one combinational read port.
module tw_regbank #(
    parameter int                 AW        = 7,
    parameter int                 DW        = 16,
    parameter logic [(1<<AW)-1:0] VALID_MAP = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int DEPTH = 1 << AW;

    logic [DEPTH-1:0][DW-1:0] cells;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        if (VALID_MAP[i]) begin : g_live
            logic [DW-1:0] word_q;
            // Storage for an existing register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_en && wr_addr == AW'(i)) begin
                    word_q <= wr_data;
                end
            end
            assign cells[i] = word_q;
        end else begin : g_dead
            assign cells[i] = '0;
        end
    end

    // Read port: contents and existence of the addressed entry
    always_comb begin
        rd_data  = cells[rd_addr];
        rd_valid = VALID_MAP[rd_addr];
    end

endmodule

// File: rtl/tw_tx.sv
`timescale 1ns/1ps
// Return shifter. It loads a frame at fetch start and presents the MSB.
// It advances on the falling edge that follows each rising edge, and holds
// the output-enable while bits remain. Assumes rising and falling events
// never coincide.
module tw_tx #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_word,
    input  logic               abort,
    input  logic               sclk_rise,
    input  logic               sclk_fall,
    output logic               sdo,
    output logic               oe
);

    localparam int CW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] shreg;
    logic [CW-1:0]      remain;
    logic               armed;

    // Frame load, bit advance and end-of-frame handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            remain <= '0;
            armed  <= 1'b0;
        end else if (abort) begin
            remain <= '0;
            armed  <= 1'b0;
        end else if (load) begin
            shreg  <= load_word;
            remain <= CW'(FRAME_W);
            armed  <= 1'b0;
        end else if (sclk_rise && remain != '0) begin
            armed <= 1'b1;
        end else if (sclk_fall && armed) begin
            shreg  <= {shreg[FRAME_W-2:0], 1'b0};
            remain <= remain - 1'b1;
            armed  <= 1'b0;
        end
    end

    assign oe  = (remain != '0);
    assign sdo = oe & shreg[FRAME_W-1];

endmodule

// File: rtl/tw_reg_slave.sv
`timescale 1ns/1ps
// Top of the three-wire register slave. It synchronizes the three bus
// lines, frames bytes, decodes the protocol, holds the register bank and
// drives fetch replies. Assumes clk is well above the bus clock rate.
module tw_reg_slave #(
    parameter int                 SYNC_STAGES = 2,
    parameter int                 BYTE_W      = 8,
    parameter int                 AW          = 7,
    parameter int                 DW          = 16,
    parameter logic [5:0]         DEV_ADDR    = 6'b011000,
    parameter logic [(1<<AW)-1:0] VALID_MAP   =
        {{((1 << AW) / 2){1'b0}}, {((1 << AW) / 2){1'b1}}}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_mode,
    input  logic bus_clk,
    input  logic bus_din,
    output logic bus_dout,
    output logic bus_doe
);

    localparam int         FRAME_W  = 3 * BYTE_W;
    localparam int         NLINES   = 3;
    localparam logic [2:0] SYNC_RST = 3'b011;

    logic [NLINES-1:0] raw_in;
    logic [NLINES-1:0] lvl, rse, fal;

    logic              mode_lvl, mode_rise, mode_fall;
    logic              sclk_rise, sclk_fall, sdata;
    logic [BYTE_W-1:0] hdr_byte, data_byte;
    logic              hdr_complete, data_strobe;
    logic              wr_en, fetch_start;
    logic [AW-1:0]     wr_addr, rd_ptr;
    logic [DW-1:0]     wr_data, rd_data;
    logic              rd_valid;
    logic              unused_sync;

    assign raw_in = {bus_din, bus_clk, bus_mode};

    for (genvar k = 0; k < NLINES; k++) begin : g_sync
        tw_edge_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(SYNC_RST[k])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_in(raw_in[k]),
            .level   (lvl[k]),
            .rise    (rse[k]),
            .fall    (fal[k])
        );
    end

    assign mode_lvl    = lvl[0];
    assign mode_rise   = rse[0];
    assign mode_fall   = fal[0];
    assign sclk_rise   = rse[1];
    assign sclk_fall   = fal[1];
    assign sdata       = lvl[2];
    assign unused_sync = ^{lvl[1], rse[2], fal[2]};

    tw_framer #(.BYTE_W(BYTE_W)) u_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_lvl    (mode_lvl),
        .mode_rise   (mode_rise),
        .mode_fall   (mode_fall),
        .sclk_rise   (sclk_rise),
        .sdata       (sdata),
        .hdr_byte    (hdr_byte),
        .hdr_complete(hdr_complete),
        .data_byte   (data_byte),
        .data_strobe (data_strobe)
    );

    tw_ctrl #(
        .BYTE_W  (BYTE_W),
        .AW      (AW),
        .DW      (DW),
        .DEV_ADDR(DEV_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_rise   (mode_rise),
        .mode_fall   (mode_fall),
        .hdr_byte    (hdr_byte),
        .hdr_complete(hdr_complete),
        .data_byte   (data_byte),
        .data_strobe (data_strobe),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_ptr      (rd_ptr),
        .fetch_start (fetch_start)
    );

    tw_regbank #(
        .AW       (AW),
        .DW       (DW),
        .VALID_MAP(VALID_MAP)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_ptr),
        .rd_data (rd_data),
        .rd_valid(rd_valid)
    );

    tw_tx #(.FRAME_W(FRAME_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fetch_start),
        .load_word({~rd_valid, rd_ptr, rd_data}),
        .abort    (mode_fall),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sdo      (bus_dout),
        .oe       (bus_doe)
    );

endmodule

// File: rtl/tw_reg_slave_chk.sv
`timescale 1ns/1ps
// Protocol-timing checks for tw_reg_slave, attached by bind.
module tw_reg_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_lvl,
    input logic mode_rise,
    input logic mode_fall,
    input logic sclk_fall,
    input logic wr_en,
    input logic bus_dout,
    input logic bus_doe
);

    // R1: reset leaves the data line released
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !bus_doe);

    // R7: output-enable only inside a data phase
    a_r7_oe_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |-> (mode_lvl || mode_fall));

    // R7: output-enable starts two cycles after a data phase opens
    a_r7_oe_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> $past(mode_rise, 2));

    // R9: driven bit moves only after a falling bus-clock edge
    a_r9_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_doe && $past(bus_doe) && !$stable(bus_dout)) |-> $past(sclk_fall));

    // R2: register writes happen only during a data phase
    a_r2_write_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mode_lvl);

endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_lvl (mode_lvl),
    .mode_rise(mode_rise),
    .mode_fall(mode_fall),
    .sclk_fall(sclk_fall),
    .wr_en    (wr_en),
    .bus_dout (bus_dout),
    .bus_doe  (bus_doe)
);

// File: tb/sim_tw_reg_slave.sv
`timescale 1ns/1ps
// Bench for tw_reg_slave: behavioural host plus reference register model.
module sim_tw_reg_slave;

    localparam logic [5:0] DEV = 6'b011000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_mode = 1'b1;
    logic bus_clk = 1'b1;
    logic bus_din = 1'b0;
    logic bus_dout, bus_doe;

    int checks = 0;
    int errors = 0;
    bit quiet = 1'b0;
    int cycles = 0;
    int ref_mem [128];
    int ref_ptr = 0;

    always #2.5 clk = ~clk;

    tw_reg_slave u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_mode(bus_mode),
        .bus_clk (bus_clk),
        .bus_din (bus_din),
        .bus_dout(bus_dout),
        .bus_doe (bus_doe)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit ref_ok(input int a);
        return a < 64;
    endfunction

    // R7: outside fetches the output-enable must stay low on every clock
    always @(negedge clk) begin
        cycles++;
        if (quiet) chk(bus_doe == 1'b0, "R7", "oe outside fetch", bus_doe, 0);
    end

    // Watchdog
    initial begin
        wait (cycles > 190000);
        chk(1'b0, "WDOG", "watchdog expired", cycles, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic drive_bit(input logic b);
        bus_clk = 1'b0;
        bus_din = b;
        wt(8);
        bus_clk = 1'b1;
        wt(8);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) drive_bit(v[i]);
    endtask

    task automatic recv_bit(output logic b);
        bus_clk = 1'b0;
        wt(8);
        chk(bus_doe == 1'b1, "R7", "oe during reply", bus_doe, 1);
        b = bus_dout;
        bus_clk = 1'b1;
        wt(7);
        chk(bus_dout == b, "R9", "bit held while clock high", bus_dout, b);
        wt(1);
    endtask

    task automatic hdr(input logic [1:0] act, input logic [5:0] dev, input int nbits);
        logic [7:0] v;
        v = {act, dev};
        bus_mode = 1'b0;
        wt(8);
        for (int i = 0; i < nbits; i++) drive_bit(v[7-i]);
        bus_mode = 1'b1;
        wt(8);
    endtask

    task automatic wr_reg(input int a, input logic [15:0] d);
        hdr(2'b01, DEV, 8);
        send_byte({1'b0, 7'(a)});
        send_byte(d[15:8]);
        send_byte(d[7:0]);
        if (ref_ok(a)) ref_mem[a] = int'(d);
    endtask

    task automatic prep(input int a);
        hdr(2'b01, DEV, 8);
        send_byte({1'b1, 7'(a)});
        ref_ptr = a;
    endtask

    task automatic fetch(input string req);
        logic [23:0] got, exp;
        logic        b;
        exp = {~ref_ok(ref_ptr), 7'(ref_ptr),
               ref_ok(ref_ptr) ? 16'(ref_mem[ref_ptr]) : 16'h0};
        quiet = 1'b0;
        hdr(2'b11, DEV, 8);
        for (int i = 23; i >= 0; i--) begin
            recv_bit(b);
            got[i] = b;
        end
        bus_clk = 1'b0;
        wt(8);
        chk(bus_doe == 1'b0, "R7", "oe after 24 bits", bus_doe, 0);
        bus_clk = 1'b1;
        wt(8);
        quiet = 1'b1;
        chk(got[23:16] == exp[23:16], req, "flag/address byte", got[23:16], exp[23:16]);
        chk(got[15:0] == exp[15:0], req, "data word", got[15:0], exp[15:0]);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) ref_mem[i] = 0;
        wt(5);
        chk(bus_doe == 1'b0, "R1", "oe in reset", bus_doe, 0);
        rst_n = 1'b1;
        wt(4);
        quiet = 1'b1;

        // R1: pointer 0, contents zero
        fetch("R1");

        // R2 R3: basic write and split read
        wr_reg(5, 16'hA5C3);
        prep(5);
        fetch("R2");
        wr_reg(0, 16'hFFFF);
        wr_reg(63, 16'h8001);
        prep(0);
        fetch("R3");
        prep(63);
        fetch("R3");

        // R4: missing registers
        wr_reg(64, 16'h1234);
        wr_reg(127, 16'hBEEF);
        prep(64);
        fetch("R4");
        prep(127);
        fetch("R4");

        // R5: wrong device, unused actions
        hdr(2'b01, 6'b011001, 8);
        send_byte(8'h05); send_byte(8'h12); send_byte(8'h34);
        hdr(2'b00, DEV, 8);
        send_byte(8'h05); send_byte(8'h12); send_byte(8'h34);
        hdr(2'b10, DEV, 8);
        send_byte(8'h05); send_byte(8'h12); send_byte(8'h34);
        hdr(2'b11, 6'b111000, 8);
        send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
        chk(bus_doe == 1'b0, "R5", "no drive for foreign fetch", bus_doe, 0);
        prep(5);
        fetch("R5");

        // R6: trailing bytes after a write and after a read request
        wr_reg(5, 16'h1111);
        send_byte(8'h05); send_byte(8'h22); send_byte(8'h22);
        prep(5);
        send_byte(8'h00); send_byte(8'h33); send_byte(8'h33);
        fetch("R6");
        prep(0);
        fetch("R6");

        // R8: write between prepare and fetch keeps the pointer
        prep(63);
        wr_reg(5, 16'h2222);
        fetch("R8");

        // R10: seven-bit header is rejected
        hdr(2'b01, DEV, 7);
        send_byte(8'h05); send_byte(8'h99); send_byte(8'h99);
        prep(5);
        fetch("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule